// File: doc/BRIEF.md
# Automatic Serial Controller Poller

This block reads two game-controller ports once per frame with no help from the processor. Each port carries two serial data lines. The block runs a fixed sequence of steps. It pulses a shared latch line to make the controllers capture their buttons, clears four result words, and then shifts one bit from each data line into its own word until every word holds sixteen bits.

The block keeps its own divider of the master step tick. Only one step tick in every 128 acts as a poll tick. A sequence starts on a poll tick that lands on the first non-visible line, inside a fixed horizontal window. After that each poll tick advances the sequence by one step. The result words then hold their value until the next sequence clears them. An enable input gates all of this, and a frame marker forces the sequencer back to idle.

Top module: `ctrl_autopoll`

## Requirements
- R1: After reset the latch output is low, the busy flag is low and all four result words are zero.
- R2: The block counts step ticks from reset. Only the first step tick after reset, and every 128th one after it, is a poll tick. The other step ticks never start or advance a sequence.
- R3: A new sequence starts at step 0 on a poll tick when the enable is high, the vertical position equals the visible line count, and the horizontal position is from 130 to 256 inclusive. Horizontal positions 129 and 257, or any other vertical position, start nothing.
- R4: The poll tick that runs step 0 drives the latch output high one cycle later, and busy is high from then on.
- R5: The poll tick that runs step 1 drives the latch output low and sets all four result words to zero one cycle later.
- R6: On each even step from 2 to 32, every result word shifts left by one place and takes its new data bit into bit 0. The first bit received therefore ends in bit 15. Poll ticks on odd steps leave the words unchanged, whatever the data lines carry.
- R7: Each word has a fixed data line. Word 0 takes port A bit 0, word 1 takes port B bit 0, word 2 takes port A bit 1, and word 3 takes port B bit 1.
- R8: The step after 32 is 33, the idle step, and busy is low there. In idle, poll ticks outside the start condition change neither the words nor the latch.
- R9: While the enable is low, poll ticks are ignored. The step, latch and words all keep their values, and a start condition starts nothing.
- R10: A step tick with both horizontal and vertical position at zero marks a frame start. It forces the step to idle, so busy is low one cycle later, and it takes priority over a poll tick in the same cycle.
- R11: A start condition that occurs while a sequence is busy restarts the sequence at step 0 and raises the latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_tick_i | input | 1 | Master step tick; the poll divider counts these |
| hpos_i | input | HPOS_W | Current horizontal position |
| vpos_i | input | VPOS_W | Current vertical position |
| vis_lines_i | input | VPOS_W | Number of visible lines, which is also the first non-visible line |
| poll_en_i | input | 1 | Enable for automatic polling |
| port_a_i | input | 2 | Serial data lines of controller port A |
| port_b_i | input | 2 | Serial data lines of controller port B |
| latch_o | output | 1 | Shared controller latch line |
| word0_o | output | WORD_W | Result word fed by port A bit 0 |
| word1_o | output | WORD_W | Result word fed by port B bit 0 |
| word2_o | output | WORD_W | Result word fed by port A bit 1 |
| word3_o | output | WORD_W | Result word fed by port B bit 1 |
| busy_o | output | 1 | High while a sequence has steps left to run |

## Verification
A wrong step count shows on busy. Busy falls too early or too late after step 32, and that is visible within one poll period of the error. A wrong step parity, or a lane wired to the wrong line, leaves the full result words different from the sixteen-bit patterns fed in, bit by bit, by the end of the sequence. A divider that is off by one moves the latch rise by a whole step tick, and the check on the 128th tick finds it at once. A lost enable gate or a lost frame override shows on busy or latch within one poll period.

// File: rtl/ctrl_poll_pkg.sv
package ctrl_poll_pkg;

   // Action that the sequencer issues to the result bank for one poll tick
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_LATCH = 2'd1,
      ACT_CLEAR = 2'd2,
      ACT_SHIFT = 2'd3
   } poll_act_e;

   // Index of the idle step for a given word width: latch + clear + two steps per bit
   function automatic int idle_step(input int word_w);
      return 2 * word_w + 1;
   endfunction

endpackage

// File: rtl/poll_tick_gen.sv
module poll_tick_gen #(
   parameter int TICK_BITS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_tick_i,
   output logic poll_tick_o
);

   initial begin
      if (TICK_BITS < 1) $error("poll_tick_gen: TICK_BITS must be at least 1");
   end

   logic [TICK_BITS-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (step_tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign poll_tick_o = step_tick_i && (cnt_q == '0);

endmodule

// File: rtl/poll_seq.sv
module poll_seq
   import ctrl_poll_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int HPOS_W = 9,
   parameter int VPOS_W = 9,
   parameter int WIN_LO = 130,
   parameter int WIN_HI = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick_i,
   input  logic              poll_tick_i,
   input  logic [HPOS_W-1:0] hpos_i,
   input  logic [VPOS_W-1:0] vpos_i,
   input  logic [VPOS_W-1:0] vis_lines_i,
   input  logic              en_i,
   output poll_act_e         act_o,
   output logic              latch_o,
   output logic              busy_o
);

   localparam int IDLE   = idle_step(WORD_W);
   localparam int STEP_W = $clog2(IDLE + 1);

   logic [STEP_W-1:0] step_q, step_d, eff_step;
   logic              frame_start, in_window, live;
   logic              latch_q;

   assign frame_start = step_tick_i && (hpos_i == '0) && (vpos_i == '0);
   assign in_window   = (vpos_i == vis_lines_i)
                     && (hpos_i >= HPOS_W'(WIN_LO))
                     && (hpos_i <= HPOS_W'(WIN_HI));
   assign eff_step    = in_window ? '0 : step_q;
   assign live        = poll_tick_i && en_i && !frame_start
                     && (eff_step < STEP_W'(IDLE));

   always_comb begin
      act_o = ACT_NONE;
      if (live) begin
         if (eff_step == STEP_W'(0))      act_o = ACT_LATCH;
         else if (eff_step == STEP_W'(1)) act_o = ACT_CLEAR;
         else if (!eff_step[0])           act_o = ACT_SHIFT;
      end
   end

   always_comb begin
      step_d = step_q;
      if (frame_start) step_d = STEP_W'(IDLE);
      else if (live)   step_d = eff_step + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= STEP_W'(IDLE);
         latch_q <= 1'b0;
      end else begin
         step_q <= step_d;
         if (act_o == ACT_LATCH)      latch_q <= 1'b1;
         else if (act_o == ACT_CLEAR) latch_q <= 1'b0;
      end
   end

   assign latch_o = latch_q;
   assign busy_o  = (step_q < STEP_W'(IDLE));

endmodule

// File: rtl/poll_shift_bank.sv
module poll_shift_bank
   import ctrl_poll_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int LANES     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  poll_act_e                    act_i,
   input  logic [LANES-1:0]             bits_i,
   output logic [LANES-1:0][WORD_W-1:0] words_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (act_i == ACT_CLEAR) begin
            word_q <= '0;
         end else if (act_i == ACT_SHIFT) begin
            if (MSB_FIRST) word_q <= {word_q[WORD_W-2:0], bits_i[g]};
            else           word_q <= {bits_i[g], word_q[WORD_W-1:1]};
         end
      end

      assign words_o[g] = word_q;
   end

endmodule

// File: rtl/ctrl_autopoll.sv
module ctrl_autopoll
   import ctrl_poll_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int TICK_BITS = 7,
   parameter int HPOS_W    = 9,
   parameter int VPOS_W    = 9,
   parameter int WIN_LO    = 130,
   parameter int WIN_HI    = 256,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick_i,
   input  logic [HPOS_W-1:0] hpos_i,
   input  logic [VPOS_W-1:0] vpos_i,
   input  logic [VPOS_W-1:0] vis_lines_i,
   input  logic              poll_en_i,
   input  logic [1:0]        port_a_i,
   input  logic [1:0]        port_b_i,
   output logic              latch_o,
   output logic [WORD_W-1:0] word0_o,
   output logic [WORD_W-1:0] word1_o,
   output logic [WORD_W-1:0] word2_o,
   output logic [WORD_W-1:0] word3_o,
   output logic              busy_o
);

   localparam int LANES = 4;

   initial begin
      if (WORD_W < 2)                $error("ctrl_autopoll: WORD_W must be at least 2");
      if (WIN_LO > WIN_HI)           $error("ctrl_autopoll: empty start window");
      if (WIN_HI >= (1 << HPOS_W))   $error("ctrl_autopoll: HPOS_W too narrow for window");
      if (WIN_LO < 1)                $error("ctrl_autopoll: window must exclude position 0");
   end

   logic                         poll_tick;
   poll_act_e                    act;
   logic [LANES-1:0]             lane_bits;
   logic [LANES-1:0][WORD_W-1:0] words;

   // lane k takes line k/2 of port A (k even) or port B (k odd)
   assign lane_bits = {port_b_i[1], port_a_i[1], port_b_i[0], port_a_i[0]};

   poll_tick_gen #(
      .TICK_BITS (TICK_BITS)
   ) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_tick_i (step_tick_i),
      .poll_tick_o (poll_tick)
   );

   poll_seq #(
      .WORD_W (WORD_W),
      .HPOS_W (HPOS_W),
      .VPOS_W (VPOS_W),
      .WIN_LO (WIN_LO),
      .WIN_HI (WIN_HI)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_tick_i (step_tick_i),
      .poll_tick_i (poll_tick),
      .hpos_i      (hpos_i),
      .vpos_i      (vpos_i),
      .vis_lines_i (vis_lines_i),
      .en_i        (poll_en_i),
      .act_o       (act),
      .latch_o     (latch_o),
      .busy_o      (busy_o)
   );

   poll_shift_bank #(
      .WORD_W    (WORD_W),
      .LANES     (LANES),
      .MSB_FIRST (MSB_FIRST)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act),
      .bits_i  (lane_bits),
      .words_o (words)
   );

   assign word0_o = words[0];
   assign word1_o = words[1];
   assign word2_o = words[2];
   assign word3_o = words[3];

endmodule

// File: rtl/ctrl_autopoll_chk.sv
module ctrl_autopoll_chk #(
   parameter int WORD_W = 16,
   parameter int HPOS_W = 9,
   parameter int VPOS_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_tick_i,
   input logic [HPOS_W-1:0] hpos_i,
   input logic [VPOS_W-1:0] vpos_i,
   input logic              poll_en_i,
   input logic              latch_o,
   input logic [WORD_W-1:0] word0_o,
   input logic [WORD_W-1:0] word1_o,
   input logic [WORD_W-1:0] word2_o,
   input logic [WORD_W-1:0] word3_o,
   input logic              busy_o
);

   // R4: a rising latch always comes with a running sequence
   a_r4_latch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_o) |-> busy_o);

   // R5: the latch only falls on the clearing step
   a_r5_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_o) |-> (word0_o == '0 && word1_o == '0 && word2_o == '0 && word3_o == '0));

   // R9: with enable low nothing visible changes on the next edge
   a_r9_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !poll_en_i |=> ($stable(latch_o) && $stable(word0_o) && $stable(word1_o)
                      && $stable(word2_o) && $stable(word3_o)));

   // R8: an idle block never alters the result words
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(word0_o) && $stable(word1_o) && $stable(word2_o) && $stable(word3_o)));

   // R10: a frame marker forces idle
   a_r10_frame_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (step_tick_i && hpos_i == '0 && vpos_i == '0) |=> !busy_o);

endmodule

bind ctrl_autopoll ctrl_autopoll_chk #(
   .WORD_W (WORD_W),
   .HPOS_W (HPOS_W),
   .VPOS_W (VPOS_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .step_tick_i (step_tick_i),
   .hpos_i      (hpos_i),
   .vpos_i      (vpos_i),
   .poll_en_i   (poll_en_i),
   .latch_o     (latch_o),
   .word0_o     (word0_o),
   .word1_o     (word1_o),
   .word2_o     (word2_o),
   .word3_o     (word3_o),
   .busy_o      (busy_o)
);

// File: tb/ctrl_autopoll_tb.sv
module ctrl_autopoll_tb;

   localparam int WORD_W = 16;
   localparam int PERIOD = 128;
   localparam logic [8:0] VIS = 9'd224;

   // each row: {word0, word1, word2, word3} expected after a full sequence
   localparam logic [63:0] VECS [0:3] = '{
      64'hA5C3_0001_8000_FFFF,
      64'h0000_1234_FFFF_5AA5,
      64'h8001_0000_0000_0000,
      64'h0000_0000_C0DE_7E81
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             step_tick = 1'b0;
   logic [8:0]       hpos = 9'd400;
   logic [8:0]       vpos = 9'd10;
   logic             en = 1'b1;
   logic [1:0]       pa = 2'b00;
   logic [1:0]       pb = 2'b00;
   logic             latch, busy;
   logic [WORD_W-1:0] w0, w1, w2, w3;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ctrl_autopoll u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_tick_i (step_tick),
      .hpos_i      (hpos),
      .vpos_i      (vpos),
      .vis_lines_i (VIS),
      .poll_en_i   (en),
      .port_a_i    (pa),
      .port_b_i    (pb),
      .latch_o     (latch),
      .word0_o     (w0),
      .word1_o     (w1),
      .word2_o     (w2),
      .word3_o     (w3),
      .busy_o      (busy)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         step_tick = 1'b1;
      end
      @(negedge clk);
      step_tick = 1'b0;
   endtask

   function automatic logic [63:0] words();
      return {w0, w1, w2, w3};
   endfunction

   task automatic drive_bit(input logic [63:0] v, input int i);
      pa = {v[31 - i], v[63 - i]};
      pb = {v[15 - i], v[47 - i]};
   endtask

   // full sequence from idle: start, clear, 16 shifts with inverted data on odd steps
   task automatic run_full(input logic [63:0] v);
      hpos = 9'd200; vpos = VIS;
      ticks(PERIOD);
      chk(latch === 1'b1 && busy === 1'b1, "R4 latch after step 0", {latch, busy}, 2'b11);
      hpos = 9'd400;
      ticks(PERIOD);
      chk(latch === 1'b0 && words() === 64'h0, "R5 latch low and clear", words(), 64'h0);
      for (int i = 0; i < WORD_W; i++) begin
         drive_bit(v, i);
         ticks(PERIOD);
         if (i != WORD_W - 1) begin
            pa = ~pa; pb = ~pb;
            ticks(PERIOD);
         end
      end
      chk(words() === v, "R6 R7 shifted words", words(), v);
      chk(busy === 1'b0, "R8 idle after step 32", busy, 0);
      pa = 2'b11; pb = 2'b10;
      ticks(PERIOD);
      chk(words() === v && latch === 1'b0, "R8 idle holds words", words(), v);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(latch === 1'b0 && busy === 1'b0 && words() === 64'h0, "R1 reset state",
          {latch, busy, words()}, 0);

      // table of patterns, full sequences
      for (int k = 0; k < 4; k++) run_full(VECS[k]);

      // R2: only every 128th step tick polls
      hpos = 9'd400; vpos = VIS;
      ticks(1);
      hpos = 9'd200;
      ticks(PERIOD - 1);
      chk(latch === 1'b0 && busy === 1'b0, "R2 non-poll ticks ignored", {latch, busy}, 0);
      ticks(1);
      chk(latch === 1'b1 && busy === 1'b1, "R2 128th tick polls", {latch, busy}, 2'b11);

      // R10: frame marker forces idle
      hpos = 9'd0; vpos = 9'd0;
      ticks(PERIOD);
      chk(busy === 1'b0, "R10 frame start idles", busy, 0);

      // R3: start at window low edge, then clear
      hpos = 9'd130; vpos = VIS;
      ticks(PERIOD);
      chk(latch === 1'b1 && busy === 1'b1, "R3 start at 130", {latch, busy}, 2'b11);
      hpos = 9'd400;
      ticks(PERIOD);
      chk(latch === 1'b0 && words() === 64'h0, "R5 clear of old words", words(), 64'h0);

      // R11: restart while busy, at window high edge
      hpos = 9'd256;
      ticks(PERIOD);
      chk(latch === 1'b1 && busy === 1'b1, "R11 R3 restart at 256", {latch, busy}, 2'b11);
      hpos = 9'd400;
      ticks(PERIOD);

      // R9: disabled ticks frozen, then resume on an even step
      en = 1'b0; pa = 2'b11; pb = 2'b11;
      ticks(PERIOD); ticks(PERIOD);
      chk(busy === 1'b1 && latch === 1'b0 && words() === 64'h0, "R9 disabled ticks ignored",
          {latch, busy, words()}, 64'h2 << 62);
      en = 1'b1;
      ticks(PERIOD);
      chk(words() === 64'h0001_0001_0001_0001, "R6 first shift after resume",
          words(), 64'h0001_0001_0001_0001);

      // back to idle, then window misses
      hpos = 9'd0; vpos = 9'd0;
      ticks(PERIOD);
      hpos = 9'd129; vpos = VIS;
      ticks(PERIOD);
      chk(latch === 1'b0 && busy === 1'b0, "R3 no start at 129", {latch, busy}, 0);
      hpos = 9'd257;
      ticks(PERIOD);
      chk(latch === 1'b0 && busy === 1'b0, "R3 no start at 257", {latch, busy}, 0);
      hpos = 9'd200; vpos = VIS - 9'd1;
      ticks(PERIOD);
      chk(latch === 1'b0 && busy === 1'b0, "R3 no start on other line", {latch, busy}, 0);
      en = 1'b0; vpos = VIS;
      ticks(PERIOD);
      chk(latch === 1'b0 && busy === 1'b0, "R9 no start when disabled", {latch, busy}, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule